// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute stage of a 32-bit integer datapath. Each cycle it takes a 4-bit operation code, a first operand, a second operand that has already passed through the barrel shifter, the shifter's carry-out, the current condition flags and a set-flags bit. It returns the operation result, a write strobe for the destination register and the next value of the four condition flags (negative, zero, carry, overflow).

The sixteen operations fall into two classes. The logical class takes its carry flag from the shifter and keeps overflow as it was. The arithmetic class takes carry and overflow from a single 33-bit adder. For the arithmetic class, carry after a subtraction means "no borrow". Four of the operations are comparisons or tests. They never write a register and always update the flags. The other twelve write the destination, and they change the flags only when the set-flags bit is high.

All outputs are registered. A result appears one clock after its operands are presented. Register-file access and multiplication sit outside this block.

Top module: `alu_dp_core`

## Requirements
- R1: Opcodes 0 (AND), 1 (EOR), 12 (ORR) and 14 (BIC) produce A&B, A^B, A|B and A&~B respectively.
- R2: Opcode 13 (MOV) produces B and opcode 15 (MVN) produces ~B; operand A has no effect on either result.
- R3: Opcodes 4 (ADD), 5 (ADC), 2 (SUB), 3 (RSB), 6 (SBC) and 7 (RSC) produce A+B, A+B+C, A-B, B-A, A-B-(1-C) and B-A-(1-C) modulo 2^32, where C is the incoming carry flag.
- R4: Opcodes 8 (TST, A&B), 9 (TEQ, A^B), 10 (CMP, A-B) and 11 (CMN, A+B) hold the write strobe low and update the flags whatever the set-flags bit is. The flag vector is ordered [3]=N, [2]=Z, [1]=C, [0]=V.
- R5: Every opcode outside 8..11 raises the write strobe.
- R6: When flags update, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R7: When a logical-class opcode (0, 1, 8, 9, 12..15) updates flags, C is taken from the shifter carry-out and V keeps its incoming value.
- R8: For addition opcodes (4, 5, 11), C is bit 32 of the full sum including the carry-in. For subtraction opcodes (2, 3, 6, 7, 10), C is 1 when no borrow occurs.
- R9: For arithmetic opcodes (2..7, 10, 11), V is 1 exactly when the signed result falls outside the 32-bit two's-complement range.
- R10: A result-writing opcode with the set-flags bit low passes all four incoming flags through unchanged.
- R11: Outputs are registered with one cycle of latency. A synchronous active-high reset clears the result, the write strobe and the flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, from the shifter |
| shift_c_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| set_flags_i | input | 1 | Update flags for result-writing opcodes |
| result_o | output | 32 | Registered result |
| rd_we_o | output | 1 | Registered destination write strobe |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Each output (result, write strobe and flags) is due at the first rising edge after the operands are applied and is stable until the next edge. The bench drives a vector on a falling edge and holds it for one full cycle. It then compares all three outputs on the next falling edge, before it changes any input. This sampling point falls after exactly one register stage, so a result that arrives early or late is reported as a miscompare.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
  endfunction

  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

endpackage

// File: rtl/alu_dp_logic.sv
module alu_dp_logic #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  import alu_dp_pkg::*;

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: y_o = a_i & b_i;
      OP_EOR, OP_TEQ: y_o = a_i ^ b_i;
      OP_ORR:         y_o = a_i | b_i;
      OP_MOV:         y_o = b_i;
      OP_BIC:         y_o = a_i & ~b_i;
      OP_MVN:         y_o = ~b_i;
      default:        y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_dp_adder.sv
module alu_dp_adder #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_flag_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  import alu_dp_pkg::*;

  localparam int SW = WIDTH + 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [SW-1:0]    sum;

  // Subtraction is x + ~y + 1 (or + C for the carry-chained forms), so
  // the adder's carry-out is already the inverted borrow.
  always_comb begin
    x = a_i;
    y = b_i;
    cin = 1'b0;
    unique case (alu_op_e'(op_i))
      OP_ADD, OP_CMN: begin x = a_i; y = b_i;  cin = 1'b0;     end
      OP_ADC:         begin x = a_i; y = b_i;  cin = c_flag_i; end
      OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; cin = 1'b1;     end
      OP_SBC:         begin x = a_i; y = ~b_i; cin = c_flag_i; end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1;     end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = c_flag_i; end
      default:        begin x = a_i; y = b_i;  cin = 1'b0;     end
    endcase
  end

  assign sum     = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign sum_o   = sum[WIDTH-1:0];
  assign carry_o = sum[WIDTH];
  assign ovf_o   = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);
endmodule

// File: rtl/alu_dp_flags.sv
module alu_dp_flags #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] logic_y_i,
  input  logic [WIDTH-1:0] arith_y_i,
  input  logic             arith_c_i,
  input  logic             arith_v_i,
  input  logic             shift_c_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             we_o,
  output logic [3:0]       flags_o
);
  import alu_dp_pkg::*;

  logic arith, cmp, update;

  assign arith    = op_is_arith(op_i);
  assign cmp      = op_is_compare(op_i);
  assign update   = cmp | set_flags_i;
  assign result_o = arith ? arith_y_i : logic_y_i;
  assign we_o     = ~cmp;

  always_comb begin
    flags_o = flags_i;
    if (update) begin
      flags_o[FLAG_N] = result_o[WIDTH-1];
      flags_o[FLAG_Z] = (result_o == '0);
      flags_o[FLAG_C] = arith ? arith_c_i : shift_c_i;
      flags_o[FLAG_V] = arith ? arith_v_i : flags_i[FLAG_V];
    end
  end
endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             shift_c_i,
  input  logic [3:0]       flags_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             rd_we_o,
  output logic [3:0]       flags_o
);
  import alu_dp_pkg::*;

  logic [WIDTH-1:0] logic_y, arith_y, res_nx;
  logic             arith_c, arith_v, we_nx;
  logic [3:0]       flags_nx;

  alu_dp_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op_i), .a_i (opa_i), .b_i (opb_i), .y_o (logic_y)
  );

  alu_dp_adder #(.WIDTH(WIDTH)) u_adder (
    .op_i (op_i), .a_i (opa_i), .b_i (opb_i), .c_flag_i (flags_i[FLAG_C]),
    .sum_o (arith_y), .carry_o (arith_c), .ovf_o (arith_v)
  );

  alu_dp_flags #(.WIDTH(WIDTH)) u_flags (
    .op_i (op_i), .set_flags_i (set_flags_i),
    .logic_y_i (logic_y), .arith_y_i (arith_y),
    .arith_c_i (arith_c), .arith_v_i (arith_v), .shift_c_i (shift_c_i),
    .flags_i (flags_i), .result_o (res_nx), .we_o (we_nx), .flags_o (flags_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      rd_we_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= res_nx;
      rd_we_o  <= we_nx;
      flags_o  <= flags_nx;
    end
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && op_is_compare($past(op_i))) |-> !rd_we_o); // R4

  AST_WRITE_OPS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !op_is_compare($past(op_i))) |-> rd_we_o); // R5

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (op_is_compare($past(op_i)) || $past(set_flags_i)))
      |-> (flags_o[FLAG_N] == result_o[WIDTH-1] &&
           flags_o[FLAG_Z] == (result_o == '0))); // R6

  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !op_is_arith($past(op_i)))
      |-> (flags_o[FLAG_V] == $past(flags_i[FLAG_V]))); // R7

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !op_is_compare($past(op_i)) && !$past(set_flags_i))
      |-> (flags_o == $past(flags_i))); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !rd_we_o && flags_o == '0)); // R11
endmodule

// File: tb/alu_dp_core_tb.sv
module alu_dp_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG = 50000;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    op;
  logic [W-1:0]  a, b;
  logic          shc;
  logic [3:0]    fl;
  logic          sf;
  logic [W-1:0]  result;
  logic          we;
  logic [3:0]    flo;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_dp_core #(.WIDTH(W)) dut_i (
    .clk (clk), .rst (rst), .op_i (op), .opa_i (a), .opb_i (b),
    .shift_c_i (shc), .flags_i (fl), .set_flags_i (sf),
    .result_o (result), .rd_we_o (we), .flags_o (flo)
  );

  function automatic bit is_arith(input logic [3:0] o);
    return (o inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});
  endfunction

  task automatic model(input logic [3:0] o, input logic [W-1:0] xa,
                       input logic [W-1:0] xb, input logic sc,
                       input logic [3:0] fi, input logic s,
                       output logic [W-1:0] r, output logic w,
                       output logic [3:0] fo);
    longint ua, ub, sa, sb, cu, us, ss;
    bit c, v;
    ua = longint'(xa); ub = longint'(xb);
    sa = longint'($signed(xa)); sb = longint'($signed(xb));
    cu = fi[1] ? 1 : 0;
    c = sc; v = fi[0];
    r = '0;
    case (o)
      4'd0, 4'd8:  r = xa & xb;
      4'd1, 4'd9:  r = xa ^ xb;
      4'd12:       r = xa | xb;
      4'd13:       r = xb;
      4'd14:       r = xa & ~xb;
      4'd15:       r = ~xb;
      default: begin
        case (o)
          4'd4, 4'd11: begin us = ua + ub;      ss = sa + sb;      end
          4'd5:        begin us = ua + ub + cu; ss = sa + sb + cu; end
          4'd2, 4'd10: begin us = ua - ub;      ss = sa - sb;      end
          4'd3:        begin us = ub - ua;      ss = sb - sa;      end
          4'd6:        begin us = ua - ub - (1 - cu); ss = sa - sb - (1 - cu); end
          default:     begin us = ub - ua - (1 - cu); ss = sb - sa - (1 - cu); end
        endcase
        r = us[W-1:0];
        if (o inside {4'd4, 4'd5, 4'd11}) c = (us >= 64'sd4294967296);
        else                             c = (us >= 0);
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
    endcase
    w = !(o inside {4'd8, 4'd9, 4'd10, 4'd11});
    if (!w || s) begin
      fo[3] = r[W-1];
      fo[2] = (r == '0);
      fo[1] = is_arith(o) ? c : sc;
      fo[0] = is_arith(o) ? v : fi[0];
    end else begin
      fo = fi;
    end
  endtask

  task automatic apply(input string req, input logic [3:0] o,
                       input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic sc, input logic [3:0] fi, input logic s);
    logic [W-1:0] er;
    logic ew;
    logic [3:0] ef;
    @(negedge clk);
    op = o; a = xa; b = xb; shc = sc; fl = fi; sf = s;
    model(o, xa, xb, sc, fi, s, er, ew, ef);
    @(negedge clk);
    vectors++;
    if (result !== er || we !== ew || flo !== ef) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h: got res=%h we=%b fl=%b, expected res=%h we=%b fl=%b",
               req, o, xa, xb, result, we, flo, er, ew, ef);
    end
  endtask

  initial begin
    rst = 1'b1; op = '0; a = '0; b = '0; shc = 1'b0; fl = 4'hF; sf = 1'b1;
    repeat (3) @(negedge clk);
    vectors++;
    if (result !== '0 || we !== 1'b0 || flo !== 4'h0) begin
      fails++;
      $display("FAIL R11 reset: got res=%h we=%b fl=%b, expected 0 0 0000", result, we, flo);
    end
    rst = 1'b0;

    // R1 logical results
    apply("R1 AND", 4'd0,  32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0, 4'b0000, 1'b1);
    apply("R1 EOR", 4'd1,  32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 4'b0001, 1'b1);
    apply("R1 ORR", 4'd12, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'b0000, 1'b1);
    apply("R1 BIC", 4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 4'b0000, 1'b1);
    // R2 MOV/MVN ignore A: same B, different A
    apply("R2 MOV", 4'd13, 32'h1234_5678, 32'hCAFE_0000, 1'b0, 4'b0000, 1'b1);
    apply("R2 MOV", 4'd13, 32'hFFFF_FFFF, 32'hCAFE_0000, 1'b0, 4'b0000, 1'b1);
    apply("R2 MVN", 4'd15, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 4'b0000, 1'b1);
    apply("R2 MVN", 4'd15, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 1'b1, 4'b0000, 1'b1);
    // R3 arithmetic results
    apply("R3 RSB", 4'd3,  32'd10, 32'd3, 1'b0, 4'b0000, 1'b1);
    apply("R3 SBC C=0", 4'd6, 32'd10, 32'd3, 1'b0, 4'b0000, 1'b1);
    apply("R3 RSC C=1", 4'd7, 32'd3, 32'd10, 1'b0, 4'b0010, 1'b1);
    // R4 compares never write, update flags even with S clear
    apply("R4 TST", 4'd8,  32'h0000_00F0, 32'h0000_000F, 1'b1, 4'b0001, 1'b0);
    apply("R4 TEQ", 4'd9,  32'h8000_0000, 32'h0000_0000, 1'b0, 4'b0000, 1'b0);
    apply("R4 CMP", 4'd10, 32'd5, 32'd5, 1'b0, 4'b1001, 1'b0);
    apply("R4 CMN", 4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b0);
    // R5/R6 write strobe, N and Z
    apply("R5 R6 SUB zero", 4'd2, 32'h7777_7777, 32'h7777_7777, 1'b0, 4'b0000, 1'b1);
    apply("R6 N set", 4'd2, 32'd0, 32'd1, 1'b0, 4'b0000, 1'b1);
    // R7 logical takes shifter carry, keeps V
    apply("R7 C from shifter, V kept", 4'd0, 32'h1, 32'h1, 1'b1, 4'b0001, 1'b1);
    apply("R7 C cleared, V kept 0", 4'd13, 32'h0, 32'h5, 1'b0, 4'b0010, 1'b1);
    // R8 carry
    apply("R8 ADC carry from carry-in", 4'd5, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010, 1'b1);
    apply("R8 ADD carry", 4'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000, 1'b1);
    apply("R8 SUB borrow", 4'd2, 32'd0, 32'd1, 1'b1, 4'b0010, 1'b1);
    apply("R8 SBC no borrow", 4'd6, 32'd1, 32'd0, 1'b0, 4'b0000, 1'b1);
    // R9 overflow
    apply("R9 ADD overflow", 4'd4, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b1);
    apply("R9 SUB overflow", 4'd2, 32'h8000_0000, 32'd1, 1'b0, 4'b0000, 1'b1);
    apply("R9 RSB overflow", 4'd3, 32'd1, 32'h8000_0000, 1'b0, 4'b0000, 1'b1);
    // R10 S clear holds flags
    apply("R10 ADD hold", 4'd4, 32'hFFFF_FFFF, 32'd1, 1'b1, 4'b1010, 1'b0);
    apply("R10 AND hold", 4'd0, 32'h0, 32'h0, 1'b1, 4'b0101, 1'b0);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ro;
      logic [W-1:0] ra, rb;
      ro = 4'($urandom_range(0, 15));
      ra = $urandom;
      rb = $urandom;
      case ($urandom_range(0, 7))
        0: rb = ra;
        1: ra = 32'h7FFF_FFFF;
        2: rb = 32'h8000_0000;
        3: ra = 32'hFFFF_FFFF;
        default: ;
      endcase
      if (ro inside {4'd8, 4'd9, 4'd10, 4'd11})
        apply("R4 random compare", ro, ra, rb, 1'($urandom), 4'($urandom), 1'($urandom));
      else if (is_arith(ro))
        apply("R8 R9 random arith", ro, ra, rb, 1'($urandom), 4'($urandom), 1'($urandom));
      else
        apply("R1 R7 random logic", ro, ra, rb, 1'($urandom), 4'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule